// File: doc/BRIEF.md
# Cascadable Up/Down Binary Counter

This block is a presettable binary counter of parameterised width (four bits by default) that counts up or down on a single clock. A direction input chooses the counting direction. A synchronous active-low load copies a parallel data word into the counter. Two active-low count enables must both be asserted for the counter to advance.

The block has an active-low carry output. It marks the terminal count for the current direction, and only the second enable (the chain enable) gates it. Wider counters are built by wiring one stage's carry straight into the chain enable of the next stage, with no extra gates. The carry is decoded combinationally, so the next stage sees it within the same cycle.

Every state change happens on the rising clock edge. A synchronous active-high reset clears the count.

Top module: `updn_cascade_ctr`

## Requirements
- R1: While `rst` is high at a rising edge, the count becomes all zeros after that edge. Reset takes priority over load and over counting.
- R2: When `ld_n` is low at a rising edge, `q` takes the value of `din` after that edge, whatever the values of both enables and of `dir_up`.
- R3: When `ld_n` is high and `cnt_en_n` and `chain_en_n` are both low, with `dir_up` = 1, `q` increases by one at the edge.
- R4: When `ld_n` is high and `cnt_en_n` and `chain_en_n` are both low, with `dir_up` = 0, `q` decreases by one at the edge.
- R5: Counting wraps modulo 2^WIDTH: up from all ones gives all zeros, and down from all zeros gives all ones.
- R6: When `ld_n` is high and `cnt_en_n` is high, `q` holds its value at the edge.
- R7: When `ld_n` is high and `chain_en_n` is high, `q` holds its value at the edge.
- R8: `carry_n` is low exactly when `chain_en_n` is low and either `dir_up` = 1 with `q` all ones, or `dir_up` = 0 with `q` all zeros. It follows these inputs in the same cycle, without waiting for a clock edge.
- R9: Two stages form an 8-bit counter when they share `cnt_en_n` and the lower stage's `carry_n` drives the upper stage's `chain_en_n`. The pair then counts up and down modulo 256 across the nibble boundary.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| dir_up | input | 1 | 1 = count up, 0 = count down |
| ld_n | input | 1 | Synchronous parallel load, active low |
| din | input | WIDTH | Parallel load data |
| cnt_en_n | input | 1 | Count enable, active low; does not gate the carry |
| chain_en_n | input | 1 | Count enable, active low; also gates `carry_n` |
| q | output | WIDTH | Registered count |
| carry_n | output | 1 | Active-low terminal-count carry |

## Verification
The bench targets the two wrap points. A counter that saturated or used the wrong terminal value there would stick at all ones or at zero instead of rolling over.

It also checks the carry in several conditions:
- Holding the counter with only the count enable deasserted. A design that gated the carry with the wrong enable would drop the carry here.
- Holding with the chain enable deasserted. A design that ignored gating would pulse the carry here.
- Flipping the direction while the count sits at a terminal value. A design that decoded a fixed terminal count would miss this.

Load is tested with both enables asserted, to show that load wins over counting. The two-stage chain is run through both nibble boundaries. A registered carry, or a carry decoded from the wrong direction, would make the upper nibble step one cycle late or in the wrong place.

// File: rtl/updn_ctr_pkg.sv
package updn_ctr_pkg;
  typedef enum logic {
    DIR_DOWN = 1'b0,
    DIR_UP   = 1'b1
  } dir_e;

  typedef enum logic [1:0] {
    OP_HOLD  = 2'd0,
    OP_LOAD  = 2'd1,
    OP_COUNT = 2'd2
  } ctr_op_e;
endpackage

// File: rtl/ctr_op_decode.sv
module ctr_op_decode
  import updn_ctr_pkg::*;
(
  input  logic    ld_n,
  input  logic    cnt_en_n,
  input  logic    chain_en_n,
  output ctr_op_e op
);
  // load wins over counting; counting needs both enables asserted (low)
  always_comb begin
    if (!ld_n)                        op = OP_LOAD;
    else if (!cnt_en_n && !chain_en_n) op = OP_COUNT;
    else                              op = OP_HOLD;
  end
endmodule

// File: rtl/ctr_next_state.sv
module ctr_next_state
  import updn_ctr_pkg::*;
#(
  parameter int WIDTH = 4
) (
  input  logic [WIDTH-1:0] q,
  input  logic [WIDTH-1:0] din,
  input  ctr_op_e          op,
  input  dir_e             dir,
  output logic [WIDTH-1:0] q_nxt
);
  // bits that allow a toggle above them: ones when counting up, zeros when down
  logic [WIDTH-1:0] prop;
  logic [WIDTH-1:0] tog;
  logic [WIDTH-1:0] stepped;

  assign prop = (dir == DIR_UP) ? q : ~q;

  // lookahead: bit i toggles when every lower bit propagates
  for (genvar i = 0; i < WIDTH; i++) begin : g_tog
    if (i == 0) begin : g_lsb
      assign tog[i] = 1'b1;
    end else begin : g_upper
      assign tog[i] = &prop[i-1:0];
    end
  end

  assign stepped = q ^ tog;

  always_comb begin
    unique case (op)
      OP_LOAD:  q_nxt = din;
      OP_COUNT: q_nxt = stepped;
      default:  q_nxt = q;
    endcase
  end
endmodule

// File: rtl/ctr_tc_decode.sv
module ctr_tc_decode
  import updn_ctr_pkg::*;
#(
  parameter int WIDTH = 4
) (
  input  logic [WIDTH-1:0] q,
  input  dir_e             dir,
  input  logic             chain_en_n,
  output logic             carry_n
);
  logic [WIDTH-1:0] at_end;
  logic             term;

  // per-bit terminal match for the current direction
  for (genvar i = 0; i < WIDTH; i++) begin : g_end
    assign at_end[i] = (dir == DIR_UP) ? q[i] : ~q[i];
  end

  assign term    = &at_end;
  assign carry_n = ~(term & ~chain_en_n);
endmodule

// File: rtl/updn_cascade_ctr.sv
module updn_cascade_ctr
  import updn_ctr_pkg::*;
#(
  parameter int WIDTH = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             dir_up,
  input  logic             ld_n,
  input  logic [WIDTH-1:0] din,
  input  logic             cnt_en_n,
  input  logic             chain_en_n,
  output logic [WIDTH-1:0] q,
  output logic             carry_n
);
  localparam logic [WIDTH-1:0] RST_VAL = '0;

  ctr_op_e          op;
  dir_e             dir;
  logic [WIDTH-1:0] q_nxt;
  logic [WIDTH-1:0] q_r;

  assign dir = dir_e'(dir_up);

  ctr_op_decode u_op (
    .ld_n       (ld_n),
    .cnt_en_n   (cnt_en_n),
    .chain_en_n (chain_en_n),
    .op         (op)
  );

  ctr_next_state #(.WIDTH(WIDTH)) u_nxt (
    .q     (q_r),
    .din   (din),
    .op    (op),
    .dir   (dir),
    .q_nxt (q_nxt)
  );

  always_ff @(posedge clk) begin
    if (rst) q_r <= RST_VAL;
    else     q_r <= q_nxt;
  end

  ctr_tc_decode #(.WIDTH(WIDTH)) u_tc (
    .q          (q_r),
    .dir        (dir),
    .chain_en_n (chain_en_n),
    .carry_n    (carry_n)
  );

  assign q = q_r;
endmodule

// File: rtl/updn_cascade_ctr_chk.sv
module updn_cascade_ctr_chk #(
  parameter int WIDTH = 4
) (
  input logic             clk,
  input logic             rst,
  input logic             dir_up,
  input logic             ld_n,
  input logic [WIDTH-1:0] din,
  input logic             cnt_en_n,
  input logic             chain_en_n,
  input logic [WIDTH-1:0] q,
  input logic             carry_n
);
  localparam logic [WIDTH-1:0] ONES = '1;
  localparam logic [WIDTH-1:0] ZERO = '0;

  a_r1_reset_clears: assert property (@(posedge clk) rst |=> (q == ZERO));

  a_r2_load_wins: assert property (@(posedge clk) disable iff (rst)
    !ld_n |=> (q == $past(din)));

  a_r3_count_up: assert property (@(posedge clk) disable iff (rst)
    (ld_n && !cnt_en_n && !chain_en_n && dir_up) |=> (q == WIDTH'($past(q) + 1'b1)));

  a_r4_count_down: assert property (@(posedge clk) disable iff (rst)
    (ld_n && !cnt_en_n && !chain_en_n && !dir_up) |=> (q == WIDTH'($past(q) - 1'b1)));

  a_r5_wrap_up: assert property (@(posedge clk) disable iff (rst)
    (ld_n && !cnt_en_n && !chain_en_n && dir_up && q == ONES) |=> (q == ZERO));

  a_r6_hold_cnt_en: assert property (@(posedge clk) disable iff (rst)
    (ld_n && cnt_en_n) |=> $stable(q));

  a_r7_hold_chain_en: assert property (@(posedge clk) disable iff (rst)
    (ld_n && chain_en_n) |=> $stable(q));

  a_r8_carry_gated: assert property (@(posedge clk) disable iff (rst)
    chain_en_n |-> carry_n);

  a_r8_carry_mid_high: assert property (@(posedge clk) disable iff (rst)
    (q != ZERO && q != ONES) |-> carry_n);

  a_r8_carry_top_up: assert property (@(posedge clk) disable iff (rst)
    (!chain_en_n && dir_up && q == ONES) |-> !carry_n);
endmodule

bind updn_cascade_ctr updn_cascade_ctr_chk #(.WIDTH(WIDTH)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .dir_up     (dir_up),
  .ld_n       (ld_n),
  .din        (din),
  .cnt_en_n   (cnt_en_n),
  .chain_en_n (chain_en_n),
  .q          (q),
  .carry_n    (carry_n)
);

// File: tb/test_updn_cascade_ctr.sv
`timescale 1ns/1ps
module test_updn_cascade_ctr;
  logic       clk = 1'b0;
  logic       rst;
  logic       dir_up, ld_n, cnt_en_n, chain_en_n;
  logic [3:0] din;
  logic [3:0] q;
  logic       carry_n;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  always #2 clk = ~clk;

  updn_cascade_ctr #(.WIDTH(4)) i_updn_cascade_ctr (
    .clk(clk), .rst(rst), .dir_up(dir_up), .ld_n(ld_n), .din(din),
    .cnt_en_n(cnt_en_n), .chain_en_n(chain_en_n), .q(q), .carry_n(carry_n)
  );

  // two-stage 8-bit chain (R9)
  logic       c_dir, c_ld_n, c_en_n;
  logic [7:0] c_din;
  logic [3:0] lo_q, hi_q;
  logic       lo_c_n, hi_c_n;

  updn_cascade_ctr #(.WIDTH(4)) i_lo (
    .clk(clk), .rst(rst), .dir_up(c_dir), .ld_n(c_ld_n), .din(c_din[3:0]),
    .cnt_en_n(c_en_n), .chain_en_n(c_en_n), .q(lo_q), .carry_n(lo_c_n)
  );
  updn_cascade_ctr #(.WIDTH(4)) i_hi (
    .clk(clk), .rst(rst), .dir_up(c_dir), .ld_n(c_ld_n), .din(c_din[7:4]),
    .cnt_en_n(c_en_n), .chain_en_n(lo_c_n), .q(hi_q), .carry_n(hi_c_n)
  );

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // sample 1 ns after the rising edge; inputs are then changed for the next edge
  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  // row: [16:13] req id, [12] ld_n, [11] cnt_en_n, [10] chain_en_n, [9] dir_up,
  //      [8:5] din, [4:1] q after the edge, [0] carry_n with the same inputs
  localparam int NV = 13;
  localparam logic [16:0] VEC [NV] = '{
    {4'd2, 1'b0, 1'b1, 1'b1, 1'b1, 4'hE, 4'hE, 1'b1}, // R2 load, enables off
    {4'd3, 1'b1, 1'b0, 1'b0, 1'b1, 4'h0, 4'hF, 1'b0}, // R3 up, R8 top carry
    {4'd5, 1'b1, 1'b0, 1'b0, 1'b1, 4'h0, 4'h0, 1'b1}, // R5 up wrap
    {4'd5, 1'b1, 1'b0, 1'b0, 1'b0, 4'h0, 4'hF, 1'b1}, // R5 down wrap
    {4'd4, 1'b1, 1'b0, 1'b0, 1'b0, 4'h0, 4'hE, 1'b1}, // R4 down
    {4'd6, 1'b1, 1'b1, 1'b0, 1'b0, 4'h3, 4'hE, 1'b1}, // R6 hold
    {4'd7, 1'b1, 1'b0, 1'b1, 1'b1, 4'h3, 4'hE, 1'b1}, // R7 hold
    {4'd2, 1'b0, 1'b0, 1'b0, 1'b0, 4'h1, 4'h1, 1'b1}, // R2 load beats count
    {4'd4, 1'b1, 1'b0, 1'b0, 1'b0, 4'h9, 4'h0, 1'b0}, // R4 down to zero, R8
    {4'd8, 1'b1, 1'b1, 1'b0, 1'b0, 4'h9, 4'h0, 1'b0}, // R8 carry with cnt_en_n high
    {4'd8, 1'b1, 1'b0, 1'b1, 1'b0, 4'h9, 4'h0, 1'b1}, // R8 gated by chain_en_n
    {4'd2, 1'b0, 1'b1, 1'b0, 1'b1, 4'hF, 4'hF, 1'b0}, // R2 load ones, R8
    {4'd8, 1'b1, 1'b1, 1'b0, 1'b0, 4'h2, 4'hF, 1'b1}  // R8 direction flip
  };

  initial begin
    rst = 1'b1; dir_up = 1'b1; ld_n = 1'b1; cnt_en_n = 1'b1; chain_en_n = 1'b1; din = 4'h0;
    c_dir = 1'b1; c_ld_n = 1'b1; c_en_n = 1'b1; c_din = 8'h00;
    tick(); tick();
    chk("R1 reset value", {4'h0, q}, 8'h00);
    rst = 1'b0;

    for (int i = 0; i < NV; i++) begin
      logic [16:0] v;
      v = VEC[i];
      ld_n = v[12]; cnt_en_n = v[11]; chain_en_n = v[10]; dir_up = v[9]; din = v[8:5];
      tick();
      chk($sformatf("R%0d row %0d q", v[16:13], i), {4'h0, q}, {4'h0, v[4:1]});
      chk($sformatf("R%0d row %0d carry_n", v[16:13], i), {7'h0, carry_n}, {7'h0, v[0]});
    end

    // R1 reset overrides a simultaneous load
    ld_n = 1'b0; din = 4'hA; rst = 1'b1;
    tick();
    chk("R1 reset beats load", {4'h0, q}, 8'h00);
    rst = 1'b0; ld_n = 1'b1;

    // R8 carry responds to chain_en_n without a clock edge
    dir_up = 1'b0; cnt_en_n = 1'b1; chain_en_n = 1'b1;
    #0.5;
    chk("R8 carry idle", {7'h0, carry_n}, 8'h01);
    chain_en_n = 1'b0;
    #0.5;
    chk("R8 carry same cycle", {7'h0, carry_n}, 8'h00);
    chain_en_n = 1'b1;

    // R9 chain: up through 0xFE..0x01
    c_ld_n = 1'b0; c_din = 8'hFE; c_en_n = 1'b1; c_dir = 1'b1;
    tick();
    chk("R9 chain load", {hi_q, lo_q}, 8'hFE);
    c_ld_n = 1'b0; c_din = 8'hFF;
    tick();
    c_ld_n = 1'b1; c_en_n = 1'b0;
    #0.5;
    chk("R9 top carry", {7'h0, hi_c_n}, 8'h00);
    tick();
    chk("R9 up wrap", {hi_q, lo_q}, 8'h00);
    c_ld_n = 1'b0; c_din = 8'h0F; c_en_n = 1'b1;
    tick();
    c_ld_n = 1'b1; c_en_n = 1'b0;
    tick();
    chk("R9 nibble carry up", {hi_q, lo_q}, 8'h10);
    c_dir = 1'b0;
    tick();
    chk("R9 nibble borrow down", {hi_q, lo_q}, 8'h0F);
    // R9 long run: 300 down counts modulo 256
    for (int k = 1; k <= 300; k++) begin
      tick();
      chk("R9 down run", {hi_q, lo_q}, 8'(8'h0F - k));
    end
    c_dir = 1'b1;
    for (int k = 1; k <= 300; k++) begin
      tick();
      chk("R9 up run", {hi_q, lo_q}, 8'(8'h0F - 300 + k));
    end
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog actual=hung expected=done");
      end
    join_any
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule